// File: doc/BRIEF.md
# Root Port PME and System-Error Register Logic

This block holds the root-port control and status registers that handle power-management event (PME) messages and error escalation. It sits on a simple configuration bus with a dword address, byte enables, a one-cycle write strobe and a combinational read path. Each PME message arrives as a one-cycle strobe carrying a 16-bit requestor ID. The block latches the first message into a status bit with its ID. It holds at most one further message aside as pending. When the status bit is cleared by software, the held message is promoted into status. While status is set and the interrupt enable is on, a level interrupt request is driven.

The same control register carries three system-error enables, one for each error class: fatal, non-fatal and correctable. Error reports come in as per-source strobe vectors, one bit per source, covering the port itself and the devices below it. A report of an enabled class, together with the command register's SERR enable input, produces a one-cycle system-error pulse.

Top module: `rp_pme_err_regs`

## Requirements
- R1: After reset both registers read 0, `pme_irq` is 0 and `serr_pulse` is 0.
- R2: The control register sits at dword offset 0x5C. Bit 3 is the PME interrupt enable, bit 2 is the fatal-error SERR enable, bit 1 is the non-fatal SERR enable and bit 0 is the correctable SERR enable. These four bits are written only when `cfg_be[0]` is set. Bits 31:4 read 0 and ignore writes.
- R3: The status register sits at dword offset 0x60. Bits 15:0 hold the requestor ID, bit 16 is PME status and bit 17 is PME pending. A PME that arrives while status is 0 sets status and loads its ID. Both are readable after the next clock edge.
- R4: A PME that arrives while status is 1 and pending is 0 sets pending. Status and the ID that reads back are left unchanged.
- R5: A PME that arrives while pending is already 1 is discarded. It never appears in the ID field.
- R6: A write to 0x60 with `cfg_be[2]` set and bit 16 set clears status when nothing is pending. Writing 0 to bit 16 has no effect. Bits 15:0 and 17 ignore writes.
- R7: A status clear while pending is 1 leaves status at 1, loads the held ID and clears pending, all at the same edge.
- R8: A PME in the same cycle as a status clear takes status with its own ID. Pending is unchanged.
- R9: `pme_irq` is high exactly while status and the interrupt enable are both 1. This includes the case where the enable is written to 1 while status is already set.
- R10: `serr_pulse` is high in the cycle after a cycle in which `cmd_serr_en` was 1 and some source reported an error of a class whose enable was 1. In every other cycle it is low.
- R11: Status bits 31:18 read 0, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address (dword aligned) |
| cfg_be | input | 4 | Write byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| pme_vld | input | 1 | PME message strobe |
| pme_rid | input | RID_W | Requestor ID of the PME message |
| err_fatal | input | N_SRC | Fatal error report per source |
| err_nonfatal | input | N_SRC | Non-fatal error report per source |
| err_corr | input | N_SRC | Correctable error report per source |
| cmd_serr_en | input | 1 | SERR enable from the command register |
| pme_irq | output | 1 | PME interrupt request level |
| serr_pulse | output | 1 | One-cycle system-error pulse |

## Verification
Register effects of a write or a PME appear one edge after the stimulus. The bench therefore samples the read path at the falling edge that follows the stimulus edge, with the bus idle and the address pointed at each register in turn. `pme_irq` follows the registered status and enable without extra delay, so it is compared in the same sampling window. `serr_pulse` is registered once, so its expected value is computed from the enables in force at the stimulus edge and checked in that same window. A control-register write in the same cycle as an error report therefore does not affect that report.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
    localparam int unsigned CFG_W       = 32;
    localparam logic [11:0] RCTL_OFF    = 12'h05C;
    localparam logic [11:0] RSTS_OFF    = 12'h060;
    localparam int unsigned ERR_CLASSES = 3;
    localparam int unsigned CLS_COR     = 0;
    localparam int unsigned CLS_NF      = 1;
    localparam int unsigned CLS_FAT     = 2;

    // packed order gives the register bit layout: bit 3 down to bit 0
    typedef struct packed {
        logic pme_ie;
        logic se_fat;
        logic se_nf;
        logic se_cor;
    } rctl_t;
endpackage

// File: rtl/rpe_ctl_reg.sv
module rpe_ctl_reg
    import rpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic       byte0_en,
    input  logic [3:0] wr_bits,
    output rctl_t      ctl_q
);
    rctl_t ctl_d;
    rctl_t ctl_r;

    always_comb begin
        ctl_d = ctl_r;
        if (wr_hit && byte0_en) begin
            ctl_d = rctl_t'(wr_bits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_r <= '0;
        end else begin
            ctl_r <= ctl_d;
        end
    end

    assign ctl_q = ctl_r;
endmodule

// File: rtl/rpe_pme_track.sv
module rpe_pme_track #(
    parameter int unsigned RID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pme_vld,
    input  logic [RID_W-1:0] pme_id,
    input  logic             clr_req,
    output logic             st_o,
    output logic             pd_o,
    output logic [RID_W-1:0] rid_o
);
    typedef struct packed {
        logic             st;
        logic             pd;
        logic [RID_W-1:0] rid;
        logic [RID_W-1:0] held;
    } trk_t;

    trk_t trk_q;
    trk_t trk_d;

    always_comb begin
        trk_d = trk_q;
        if (clr_req && trk_q.st) begin
            if (pme_vld) begin
                // arriving message takes ownership of status
                trk_d.rid = pme_id;
            end else if (trk_q.pd) begin
                trk_d.rid = trk_q.held;
                trk_d.pd  = 1'b0;
            end else begin
                trk_d.st = 1'b0;
            end
        end else if (pme_vld) begin
            if (!trk_q.st) begin
                trk_d.st  = 1'b1;
                trk_d.rid = pme_id;
            end else if (!trk_q.pd) begin
                trk_d.pd   = 1'b1;
                trk_d.held = pme_id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign st_o  = trk_q.st;
    assign pd_o  = trk_q.pd;
    assign rid_o = trk_q.rid;
endmodule

// File: rtl/rpe_serr_gen.sv
module rpe_serr_gen
    import rpe_pkg::*;
#(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] err_fat,
    input  logic [N_SRC-1:0] err_nf,
    input  logic [N_SRC-1:0] err_cor,
    input  rctl_t            ctl,
    input  logic             cmd_serr_en,
    output logic             serr_o
);
    typedef struct packed {
        logic serr;
    } sg_t;

    logic [ERR_CLASSES-1:0][N_SRC-1:0] rpt;
    logic [ERR_CLASSES-1:0]            cls_en;
    logic [ERR_CLASSES-1:0]            cls_fire;
    sg_t                               sg_q;
    sg_t                               sg_d;

    assign rpt[CLS_COR]    = err_cor;
    assign rpt[CLS_NF]     = err_nf;
    assign rpt[CLS_FAT]    = err_fat;
    assign cls_en[CLS_COR] = ctl.se_cor;
    assign cls_en[CLS_NF]  = ctl.se_nf;
    assign cls_en[CLS_FAT] = ctl.se_fat;

    for (genvar c = 0; c < ERR_CLASSES; c++) begin : g_cls
        assign cls_fire[c] = cls_en[c] & (|rpt[c]);
    end

    always_comb begin
        sg_d      = sg_q;
        sg_d.serr = cmd_serr_en & (|cls_fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_q <= '0;
        end else begin
            sg_q <= sg_d;
        end
    end

    assign serr_o = sg_q.serr;
endmodule

// File: rtl/rp_pme_err_regs.sv
module rp_pme_err_regs
    import rpe_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned RID_W  = 16,
    parameter int unsigned N_SRC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              pme_vld,
    input  logic [RID_W-1:0]  pme_rid,
    input  logic [N_SRC-1:0]  err_fatal,
    input  logic [N_SRC-1:0]  err_nonfatal,
    input  logic [N_SRC-1:0]  err_corr,
    input  logic              cmd_serr_en,
    output logic              pme_irq,
    output logic              serr_pulse
);
    localparam int unsigned ST_BIT  = RID_W;
    localparam int unsigned PD_BIT  = RID_W + 1;
    localparam int unsigned ST_BYTE = ST_BIT / 8;
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(RCTL_OFF);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(RSTS_OFF);

    logic             hit_ctl;
    logic             hit_sts;
    logic             clr_req;
    rctl_t            ctl_q;
    logic             pme_status;
    logic             pme_pending;
    logic [RID_W-1:0] pme_rid_q;
    logic             unused_cfg;

    assign hit_ctl = (cfg_addr[ADDR_W-1:2] == A_CTL[ADDR_W-1:2]);
    assign hit_sts = (cfg_addr[ADDR_W-1:2] == A_STS[ADDR_W-1:2]);
    assign clr_req = cfg_wr & hit_sts & cfg_be[ST_BYTE] & cfg_wdata[ST_BIT];
    assign unused_cfg = ^{cfg_addr[1:0], cfg_be, cfg_wdata};

    rpe_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (cfg_wr & hit_ctl),
        .byte0_en (cfg_be[0]),
        .wr_bits  (cfg_wdata[3:0]),
        .ctl_q    (ctl_q)
    );

    rpe_pme_track #(.RID_W(RID_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pme_vld (pme_vld),
        .pme_id  (pme_rid),
        .clr_req (clr_req),
        .st_o    (pme_status),
        .pd_o    (pme_pending),
        .rid_o   (pme_rid_q)
    );

    rpe_serr_gen #(.N_SRC(N_SRC)) u_serr (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_fat     (err_fatal),
        .err_nf      (err_nonfatal),
        .err_cor     (err_corr),
        .ctl         (ctl_q),
        .cmd_serr_en (cmd_serr_en),
        .serr_o      (serr_pulse)
    );

    always_comb begin
        cfg_rdata = '0;
        if (hit_ctl) begin
            cfg_rdata[3:0] = ctl_q;
        end else if (hit_sts) begin
            cfg_rdata[RID_W-1:0] = pme_rid_q;
            cfg_rdata[ST_BIT]    = pme_status;
            cfg_rdata[PD_BIT]    = pme_pending;
        end
    end

    assign pme_irq = pme_status & ctl_q.pme_ie;
endmodule

// File: rtl/rpe_chk.sv
module rpe_chk #(
    parameter int unsigned RID_W = 16,
    parameter int unsigned N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_req,
    input logic             pme_vld,
    input logic             st,
    input logic             pd,
    input logic [RID_W-1:0] rid,
    input logic [3:0]       ctl,
    input logic             irq,
    input logic             serr,
    input logic             cmd_serr_en,
    input logic [N_SRC-1:0] err_fatal
);
    p_pend_needs_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd |-> st);

    p_rid_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st && !clr_req) |=> $stable(rid));

    p_refill_on_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && pd && !pme_vld) |=> (st && !pd));

    p_irq_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && st && !pd && !pme_vld) |=> !irq);

    p_serr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        serr |-> $past(cmd_serr_en));

    p_serr_fatal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_fatal) && ctl[2] && cmd_serr_en) |=> serr);
endmodule

bind rp_pme_err_regs rpe_chk #(.RID_W(RID_W), .N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_req     (clr_req),
    .pme_vld     (pme_vld),
    .st          (pme_status),
    .pd          (pme_pending),
    .rid         (pme_rid_q),
    .ctl         (ctl_q),
    .irq         (pme_irq),
    .serr        (serr_pulse),
    .cmd_serr_en (cmd_serr_en),
    .err_fatal   (err_fatal)
);

// File: tb/rp_pme_err_regs_bench.sv
`timescale 1ns/1ps
module rp_pme_err_regs_bench;
    localparam int ADDR_W = 12;
    localparam int RID_W  = 16;
    localparam int N_SRC  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [3:0]        cfg_be = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              pme_vld = 1'b0;
    logic [RID_W-1:0]  pme_rid = '0;
    logic [N_SRC-1:0]  err_fatal = '0;
    logic [N_SRC-1:0]  err_nonfatal = '0;
    logic [N_SRC-1:0]  err_corr = '0;
    logic              cmd_serr_en = 1'b0;
    logic              pme_irq;
    logic              serr_pulse;

    always #2 clk = ~clk;

    rp_pme_err_regs #(.ADDR_W(ADDR_W), .RID_W(RID_W), .N_SRC(N_SRC)) u_rp_pme_err_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pme_vld(pme_vld), .pme_rid(pme_rid),
        .err_fatal(err_fatal), .err_nonfatal(err_nonfatal), .err_corr(err_corr),
        .cmd_serr_en(cmd_serr_en), .pme_irq(pme_irq), .serr_pulse(serr_pulse)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [3:0]  m_ctl = '0;
    logic        m_st = 1'b0;
    logic        m_pd = 1'b0;
    logic [15:0] m_rid = '0;
    logic [15:0] m_held = '0;
    logic        m_serr = 1'b0;

    function automatic logic [31:0] exp_ctl_rd();
        return {28'd0, m_ctl};
    endfunction

    function automatic logic [31:0] exp_sts_rd();
        return {14'd0, m_pd, m_st, m_rid};
    endfunction

    function automatic logic exp_serr_next();
        return cmd_serr_en && (((|err_fatal) && m_ctl[2]) ||
                               ((|err_nonfatal) && m_ctl[1]) ||
                               ((|err_corr) && m_ctl[0]));
    endfunction

    task automatic model_edge();
        logic clr;
        logic [3:0] ctl_old;
        ctl_old = m_ctl;
        clr = cfg_wr && cfg_addr == 12'h060 && cfg_be[2] && cfg_wdata[16];
        m_serr = exp_serr_next();
        if (clr && m_st) begin
            if (pme_vld) m_rid = pme_rid;
            else if (m_pd) begin m_rid = m_held; m_pd = 1'b0; end
            else m_st = 1'b0;
        end else if (pme_vld) begin
            if (!m_st) begin m_st = 1'b1; m_rid = pme_rid; end
            else if (!m_pd) begin m_pd = 1'b1; m_held = pme_rid; end
        end
        if (cfg_wr && cfg_addr == 12'h05C && cfg_be[0]) m_ctl = cfg_wdata[3:0];
        else m_ctl = ctl_old;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
        pme_vld = 1'b0; pme_rid = '0;
        err_fatal = '0; err_nonfatal = '0; err_corr = '0;
    endtask

    // called at a falling edge with the bus idle
    task automatic observe(input string tag);
        cfg_addr = 12'h05C; #0.5;
        chk(tag, "ctl read", cfg_rdata, exp_ctl_rd());
        cfg_addr = 12'h060; #0.5;
        chk(tag, "status read", cfg_rdata, exp_sts_rd());
        chk(tag, "pme_irq", {31'd0, pme_irq}, {31'd0, m_st & m_ctl[3]});
        chk(tag, "serr_pulse", {31'd0, serr_pulse}, {31'd0, m_serr});
    endtask

    // stimulus already placed on the inputs; apply for one edge then observe
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
        observe(tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        observe("R1 reset");

        wr(12'h05C, 4'hF, 32'hFFFF_FFFF); step("R2 write all ones");
        wr(12'h05C, 4'hE, 32'h0000_0000); step("R2 byte0 disabled");
        cmd_serr_en = 1'b0;
        wr(12'h05C, 4'h1, 32'h0000_0008); step("R2 ie only");
        chk("R9 enable only", "irq", {31'd0, pme_irq}, 32'd0);

        pme_vld = 1'b1; pme_rid = 16'hA1A1; step("R3 first PME");
        chk("R9 irq on status", "irq", {31'd0, pme_irq}, 32'd1);
        pme_vld = 1'b1; pme_rid = 16'hB2B2; step("R4 second PME pends");
        pme_vld = 1'b1; pme_rid = 16'hC3C3; step("R5 third PME dropped");
        wr(12'h060, 4'hF, 32'hFFFF_FFFF); step("R7 clear refills from held");
        chk("R5 held id", "rid", {16'd0, cfg_rdata[15:0]}, 32'h0000_B2B2);
        wr(12'h060, 4'hB, 32'hFFFE_FFFF); step("R6 zero on status bit");
        wr(12'h060, 4'h4, 32'h0001_0000); step("R6 clear");
        chk("R9 irq falls", "irq", {31'd0, pme_irq}, 32'd0);
        wr(12'h060, 4'hF, 32'h0001_0000); step("R6 clear with nothing set");

        pme_vld = 1'b1; pme_rid = 16'h1111; step("R3 owner");
        pme_vld = 1'b1; pme_rid = 16'h2222; step("R4 pend");
        wr(12'h060, 4'h4, 32'h0001_0000); pme_vld = 1'b1; pme_rid = 16'h3333;
        step("R8 same-cycle clear and PME");

        wr(12'h05C, 4'h1, 32'h0); step("R9 ie off with status set");
        wr(12'h05C, 4'h1, 32'h8); step("R9 ie on with status set");

        wr(12'h05C, 4'h1, 32'h4); step("R10 fatal enable only");
        cmd_serr_en = 1'b0; err_fatal = 4'b0100; step("R10 gated by command");
        cmd_serr_en = 1'b1; err_fatal = 4'b0001; step("R10 fatal pulse");
        step("R10 pulse ends");
        err_nonfatal = 4'b1000; err_corr = 4'b0010; step("R10 disabled classes");
        wr(12'h05C, 4'h1, 32'h3); err_corr = 4'b0001; step("R10 old enables apply");
        err_corr = 4'b1000; step("R10 correctable enabled");

        cfg_addr = 12'h064; #0.5;
        chk("R11 other offset", "rdata", cfg_rdata, 32'd0);
        cfg_addr = 12'h058; #0.5;
        chk("R11 other offset", "rdata", cfg_rdata, 32'd0);

        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) < 35) begin
                int sel = $urandom_range(0, 3);
                logic [11:0] a;
                a = (sel == 0) ? 12'h05C : (sel == 1) ? 12'h060 : (sel == 2) ? 12'h064 : 12'h058;
                wr(a, 4'($urandom), $urandom);
            end
            if ($urandom_range(0, 99) < 40) begin
                pme_vld = 1'b1; pme_rid = 16'($urandom);
            end
            if ($urandom_range(0, 99) < 20) err_fatal = 4'($urandom);
            if ($urandom_range(0, 99) < 20) err_nonfatal = 4'($urandom);
            if ($urandom_range(0, 99) < 20) err_corr = 4'($urandom);
            cmd_serr_en = ($urandom_range(0, 99) < 70);
            step("R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule